// File: doc/BRIEF.md
# Cascade Bus-Master Sequencer

This block sits on an add-in card and wins ownership of the legacy expansion bus by way of a host DMA channel that has been set to cascade operation. Local logic raises a level request and names a channel and a transfer width. The block then raises that channel's request line and waits for the host's active-low acknowledge. The acknowledge arrives asynchronously, so it passes through a two-flop synchroniser first.

Once the acknowledge is seen, the block pulls the master line low. It enables the address and data drivers one bus clock later, and permits read or write strobes two bus clocks after the master line fell. The clock is the bus clock. Local logic performs its transfers while `cmd_en` is high and pulses `xfer_done` when it has finished.

Release takes one clock per step, in this order: strobes off, drivers off, master line high, request low. A tenure counter bounds how long the master line stays low, so that host memory refresh is never starved. If local logic is still busy when the bound is reached, the block forces the same release and flags a timeout.

Top module: `cbm_master`

## Requirements
- R1: Out of reset, `drq` is all zeros, `master_n` is 1, and `drv_oe`, `cmd_en`, `timeout` and `chan_err` are 0.
- R2: While idle, a high `xfer_req` with a valid channel sets exactly the bit `drq[chan_sel]` after the next clock edge. `drq[4]` is never set.
- R3: Valid channels are 0 to 3 when `wide16`=0 and 5 to 7 when `wide16`=1. A high `xfer_req` with any other channel raises `chan_err` after the next edge, for as long as the request is held, and leaves `drq` at zero.
- R4: `master_n` falls after the third rising edge that follows `dack_n[chan]` going low. An acknowledge on any other channel has no effect.
- R5: `drv_oe` rises OE_DELAY (default 1) clocks after `master_n` falls. `cmd_en` rises CMD_DELAY (default 2) clocks after `master_n` falls.
- R6: When `xfer_done` is sampled high while `cmd_en` is high, the following happen on successive edges: `cmd_en` goes low, then `drv_oe` goes low, then `master_n` goes high, then `drq` clears.
- R7: `xfer_done` sampled while `cmd_en` is still low is ignored, and the tenure continues.
- R8: `master_n` stays low for at most TENURE_LIMIT consecutive clocks. If no done is taken by the last granted cycle, the R6 release is forced and `timeout` is high for exactly the one cycle in which `cmd_en` first reads low.
- R9: If `xfer_done` is sampled in the same cycle in which the tenure limit is reached, the release is a normal one and `timeout` stays 0.
- R10: Dropping `xfer_req` while waiting for the acknowledge clears `drq` after the next edge, and `master_n` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req | input | 1 | Local logic wants the bus (level) |
| chan_sel | input | 3 | Request channel number |
| wide16 | input | 1 | 1 = 16-bit master, 0 = 8-bit master |
| xfer_done | input | 1 | Local transfers finished (sampled only while commands are allowed) |
| dack_n | input | 8 | Per-channel acknowledge, active low, asynchronous |
| drq | output | 8 | Per-channel DMA request, active high |
| master_n | output | 1 | Bus-master line, active low |
| drv_oe | output | 1 | Address and data driver enable |
| cmd_en | output | 1 | Read/write strobes permitted |
| timeout | output | 1 | One-cycle pulse on a forced release |
| chan_err | output | 1 | Requested channel is invalid for the width |

## Verification
The tenure limit and a normal completion can fall on the same edge. The bench provokes this by running a grant of the bench's shortened limit and pulsing `xfer_done` exactly in the last granted cycle. It judges the result by requiring that `cmd_en` drops on the next edge while `timeout` stays 0, and that the master line was low for exactly the limit. A second run withholds the done signal, and there the same cycle must produce the timeout pulse instead.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CBM_NCH = 8;
  localparam int CBM_CHW = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GRANT,
    ST_REL_CMD,
    ST_REL_OE,
    ST_REL_MST
  } cbm_state_e;

  function automatic logic chan_ok(input logic [CBM_CHW-1:0] ch, input logic wide);
    if (wide) return (ch >= 3'd5);
    else      return (ch <= 3'd3);
  endfunction
endpackage

// File: rtl/cbm_sync.sv
module cbm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= {W{RST_VAL}};
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cbm_tenure.sv
module cbm_tenure #(
  parameter int LIMIT     = 112,
  parameter int OE_DELAY  = 1,
  parameter int CMD_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic oe_ok,
  output logic cmd_ok,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] T_OE   = CW'(OE_DELAY);
  localparam logic [CW-1:0] T_CMD  = CW'(CMD_DELAY);
  localparam logic [CW-1:0] T_LAST = CW'(LIMIT - 3);

  logic [CW-1:0] t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            t_q <= '0;
    else if (!run)         t_q <= '0;
    else if (t_q != T_LAST) t_q <= t_q + 1'b1;
  end

  assign oe_ok  = run && (t_q >= T_OE);
  assign cmd_ok = run && (t_q >= T_CMD);
  assign last   = run && (t_q == T_LAST);
endmodule

// File: rtl/cbm_seq.sv
module cbm_seq
  import cbm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_req,
  input  logic [CBM_CHW-1:0] chan_sel,
  input  logic               wide16,
  input  logic               xfer_done,
  input  logic [CBM_NCH-1:0] ack_n_sync,
  input  logic               cmd_ok,
  input  logic               last,
  output cbm_state_e         state,
  output logic [CBM_CHW-1:0] ch_q,
  output logic               timeout_q,
  output logic               chan_err_q
);
  cbm_state_e nxt;
  logic       force_rel;
  logic       bad_ch;

  assign bad_ch    = (state == ST_IDLE) && xfer_req && !chan_ok(chan_sel, wide16);
  assign force_rel = (state == ST_GRANT) && last && !(xfer_done && cmd_ok);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (xfer_req && chan_ok(chan_sel, wide16)) nxt = ST_REQ;
      ST_REQ: begin
        if (!xfer_req)             nxt = ST_IDLE;
        else if (!ack_n_sync[ch_q]) nxt = ST_GRANT;
      end
      ST_GRANT:   if ((xfer_done && cmd_ok) || last) nxt = ST_REL_CMD;
      ST_REL_CMD: nxt = ST_REL_OE;
      ST_REL_OE:  nxt = ST_REL_MST;
      ST_REL_MST: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ch_q       <= '0;
      timeout_q  <= 1'b0;
      chan_err_q <= 1'b0;
    end else begin
      state      <= nxt;
      timeout_q  <= force_rel;
      chan_err_q <= bad_ch;
      if (state == ST_IDLE && nxt == ST_REQ) ch_q <= chan_sel;
    end
  end
endmodule

// File: rtl/cbm_master.sv
module cbm_master
  import cbm_pkg::*;
#(
  parameter int TENURE_LIMIT = 112,
  parameter int OE_DELAY     = 1,
  parameter int CMD_DELAY    = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_req,
  input  logic [CBM_CHW-1:0] chan_sel,
  input  logic               wide16,
  input  logic               xfer_done,
  input  logic [CBM_NCH-1:0] dack_n,
  output logic [CBM_NCH-1:0] drq,
  output logic               master_n,
  output logic               drv_oe,
  output logic               cmd_en,
  output logic               timeout,
  output logic               chan_err
);
  logic [CBM_NCH-1:0] ack_n_sync;
  cbm_state_e         state;
  logic [CBM_CHW-1:0] ch_q;
  logic               run, oe_ok, cmd_ok, last;
  logic               drq_on;

  cbm_sync #(.W(CBM_NCH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dack_n), .q(ack_n_sync)
  );

  assign run = (state == ST_GRANT);

  cbm_tenure #(.LIMIT(TENURE_LIMIT), .OE_DELAY(OE_DELAY), .CMD_DELAY(CMD_DELAY)) u_ten (
    .clk(clk), .rst_n(rst_n), .run(run),
    .oe_ok(oe_ok), .cmd_ok(cmd_ok), .last(last)
  );

  cbm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .chan_sel(chan_sel),
    .wide16(wide16), .xfer_done(xfer_done), .ack_n_sync(ack_n_sync),
    .cmd_ok(cmd_ok), .last(last), .state(state), .ch_q(ch_q),
    .timeout_q(timeout), .chan_err_q(chan_err)
  );

  assign drq_on   = (state != ST_IDLE);
  assign master_n = !(state == ST_GRANT || state == ST_REL_CMD || state == ST_REL_OE);
  assign drv_oe   = oe_ok || (state == ST_REL_CMD);
  assign cmd_en   = cmd_ok;

  generate
    for (genvar i = 0; i < CBM_NCH; i++) begin : g_drq
      assign drq[i] = drq_on && (ch_q == CBM_CHW'(i));
    end
  endgenerate
endmodule

// File: rtl/cbm_master_chk.sv
module cbm_master_chk #(
  parameter int TENURE_LIMIT = 112
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] dack_n,
  input logic [7:0] drq,
  input logic       master_n,
  input logic       drv_oe,
  input logic       cmd_en,
  input logic       timeout
);
  localparam int CW = $clog2(TENURE_LIMIT + 2);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (master_n)   low_cnt <= '0;
    else if (low_cnt != {CW{1'b1}}) low_cnt <= low_cnt + 1'b1;
  end

  AST_DRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drq)); // R2
  AST_NO_CH4: assert property (@(posedge clk) disable iff (!rst_n) !drq[4]); // R2
  AST_ACK_BEFORE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_n) |-> $past((~dack_n & drq) != 8'h00)); // R4
  AST_OE_AFTER_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_oe) |-> (!master_n && $past(!master_n))); // R5
  AST_CMD_AFTER_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_en) |-> ($past(!master_n) && $past(!master_n, 2) && drv_oe)); // R5
  AST_CMD_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_en) |-> (drv_oe && !master_n)); // R6
  AST_OE_DROPS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_oe) |-> (!cmd_en && !master_n)); // R6
  AST_MASTER_BEFORE_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_n) |-> (!drv_oe && (drq != 8'h00))); // R6
  AST_TENURE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CW'(TENURE_LIMIT)); // R8
  AST_TIMEOUT_AT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!cmd_en && $past(cmd_en) && drv_oe && !master_n)); // R8
endmodule

bind cbm_master cbm_master_chk #(.TENURE_LIMIT(TENURE_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dack_n(dack_n), .drq(drq), .master_n(master_n),
  .drv_oe(drv_oe), .cmd_en(cmd_en), .timeout(timeout)
);

// File: tb/cbm_master_test.sv
module cbm_master_test;
  localparam int LIM = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       xfer_req, wide16, xfer_done;
  logic [2:0] chan_sel;
  logic [7:0] dack_n;
  logic [7:0] drq;
  logic       master_n, drv_oe, cmd_en, timeout, chan_err;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cbm_master #(.TENURE_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .chan_sel(chan_sel),
    .wide16(wide16), .xfer_done(xfer_done), .dack_n(dack_n), .drq(drq),
    .master_n(master_n), .drv_oe(drv_oe), .cmd_en(cmd_en),
    .timeout(timeout), .chan_err(chan_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Request channel ch and run up to the first cycle with master_n low.
  task automatic open_bus(input int ch, input logic w);
    chan_sel = 3'(ch); wide16 = w; xfer_req = 1'b1;
    step(1);
    chk("R2 drq bit", drq, 1 << ch);
    dack_n[ch] = 1'b0;
    step(2);
    chk("R4 master still high", master_n, 1);
    step(1);
    chk("R4 master low", master_n, 0);
    chk("R5 oe off at t0", drv_oe, 0);
  endtask

  // Check the four-step release after done/limit was taken on the previous edge.
  task automatic check_release(input int exp_to);
    xfer_done = 1'b0; xfer_req = 1'b0;
    chk("R6 cmd off", cmd_en, 0);
    chk("R6 oe still on", drv_oe, 1);
    chk("R8/R9 timeout flag", timeout, exp_to);
    step(1);
    chk("R6 oe off", drv_oe, 0);
    chk("R6 master still low", master_n, 0);
    chk("R8 timeout one cycle", timeout, 0);
    step(1);
    chk("R6 master high", master_n, 1);
    chk("R6 drq still on", (drq != 0) ? 1 : 0, 1);
    dack_n = 8'hFF;
    step(1);
    chk("R6 drq clear", drq, 0);
    step(4);
  endtask

  task automatic t_normal(input int ch, input logic w);
    open_bus(ch, w);
    step(1);
    chk("R5 oe on", drv_oe, 1);
    chk("R5 cmd off", cmd_en, 0);
    step(1);
    chk("R5 cmd on", cmd_en, 1);
    xfer_done = 1'b1;
    step(1);
    check_release(0);
  endtask

  task automatic t_early_done;
    open_bus(2, 1'b0);
    xfer_done = 1'b1;
    step(1);
    step(1);
    xfer_done = 1'b0;
    chk("R7 cmd on despite early done", cmd_en, 1);
    step(2);
    chk("R7 tenure continues", cmd_en, 1);
    chk("R7 master still low", master_n, 0);
    xfer_done = 1'b1;
    step(1);
    check_release(0);
  endtask

  task automatic t_limit(input logic done_at_limit);
    int low = 1;
    open_bus(7, 1'b1);
    for (int k = 0; k < LIM - 3; k++) begin
      step(1);
      if (!master_n) low++;
    end
    chk("R8 cmd on in last granted cycle", cmd_en, 1);
    chk("R8 no early timeout", timeout, 0);
    xfer_done = done_at_limit;
    step(1);
    if (!master_n) low++;
    if (done_at_limit) chk("R9 normal release no timeout", timeout, 0);
    check_release(done_at_limit ? 0 : 1);
    // check_release advanced one cycle with master low (REL_OE)
    low++;
    chk("R8 master low length", low, LIM);
  endtask

  task automatic t_bad_chan;
    chan_sel = 3'd5; wide16 = 1'b0; xfer_req = 1'b1;
    step(1);
    chk("R3 err for 5 at 8-bit", chan_err, 1);
    chk("R3 no drq", drq, 0);
    chan_sel = 3'd4; wide16 = 1'b1;
    step(1);
    chk("R3 err for ch4", chan_err, 1);
    chk("R3 no drq ch4", drq, 0);
    xfer_req = 1'b0;
    step(1);
    chk("R3 err clears", chan_err, 0);
    step(1);
  endtask

  task automatic t_wrong_ack;
    chan_sel = 3'd1; wide16 = 1'b0; xfer_req = 1'b1;
    step(1);
    dack_n[3] = 1'b0;
    step(5);
    chk("R4 other ack ignored", master_n, 1);
    chk("R4 drq held", drq, 2);
    dack_n[1] = 1'b0;
    step(3);
    chk("R4 own ack grants", master_n, 0);
    step(2);
    xfer_done = 1'b1;
    step(1);
    check_release(0);
  endtask

  task automatic t_abort;
    chan_sel = 3'd0; wide16 = 1'b0; xfer_req = 1'b1;
    step(1);
    chk("R10 drq on", drq, 1);
    xfer_req = 1'b0;
    step(1);
    chk("R10 drq dropped", drq, 0);
    dack_n[0] = 1'b0;
    step(4);
    chk("R10 master never low", master_n, 1);
    dack_n = 8'hFF;
    step(4);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xfer_req = 1'b0; wide16 = 1'b0; xfer_done = 1'b0;
    chan_sel = '0; dack_n = 8'hFF;
    step(3);
    chk("R1 drq", drq, 0);
    chk("R1 master_n", master_n, 1);
    chk("R1 oe", drv_oe, 0);
    chk("R1 cmd", cmd_en, 0);
    chk("R1 timeout", timeout, 0);
    chk("R1 chan_err", chan_err, 0);
    rst_n = 1'b1;
    step(2);
    t_normal(3, 1'b0);
    t_normal(6, 1'b1);
    t_early_done();
    t_bad_chan();
    t_wrong_ack();
    t_abort();
    t_limit(1'b0);
    t_limit(1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule